// File: doc/BRIEF.md
# Isochronous Serial Clock Router

This block picks the bit clocks that a serial port uses to send and to receive, and it routes clocks out onto two outgoing timing circuits. Three kinds of source exist. The first is a pair of local baud-rate generators, which arrive as single-cycle enables. The second and third are two incoming timing leads from the line equipment: one carries transmitter timing and one carries receiver timing. A 12-bit mode word holds four 3-bit fields. One field chooses the transmit source, one chooses the receive source, and two choose what drives each outgoing circuit.

The incoming timing leads are asynchronous levels. Each passes through a synchroniser and an edge detector, so that every rising edge gives one enable cycle in the system clock domain. Each generator enable toggles a level flop, which forms a square wave that can be routed out. Plain asynchronous operation is mode word zero: both directions use the local generators and no clock is driven out.

The block also supports isochronous input throttling. When throttling is armed and the receive side asks for a pause, every driven outgoing clock is held low. The far end is assumed to clock its data from that signal, so its output stops. A change of source and the start or end of a stop are applied only while the output is low. As a result, no shortened pulse ever leaves the block.

Top module: `iso_clk_router`

## Requirements
- R1: Field bits 2:0 choose the transmit bit tick. Code 0 selects the transmit generator enable, code 1 the incoming transmitter-timing lead, and code 2 the incoming receiver-timing lead. Each generator enable, and each rising edge of the selected lead, gives exactly one cycle of `tx_bit_tick`.
- R2: Field bits 5:3 choose the receive bit tick with the same codes, where code 0 selects the receive generator enable.
- R3: Input-field codes 3 to 7 behave as code 0 (local generator).
- R4: Field bits 8:6 choose what drives `timing_out_a`. Code 0 drives nothing, code 1 the receive generator level, code 2 the transmit generator level, code 3 the transmitter-timing lead and code 4 the receiver-timing lead. A generator level toggles on each of its enables, so the output gives one rising edge for every two enables, or one for every rising edge of the lead.
- R5: Field bits 11:9 choose what drives `timing_out_b`, with the same codes as R4.
- R6: An output field set to 0 or to a reserved code 5 to 7 holds its output low.
- R7: When `iso_stop_en` and `rx_stop_req` are both high, every driven output is held low. The stop begins and ends only at a point where the output is low, so every high pulse keeps the full length of its source.
- R8: While `iso_stop_en` is low, `rx_stop_req` has no effect on the outputs.
- R9: A new output source is adopted only while the output and the new source are both low, so every high pulse matches the full high time of the old or the new source.
- R10: The incoming timing leads pass through a synchroniser. Each rising edge produces an internal tick enable that lasts exactly one cycle.
- R11: After reset all four outputs are low and both generator levels are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 12 | Mode word: transmit, receive, output A and output B fields |
| brg_tx_tick | input | 1 | Transmit baud-rate generator enable |
| brg_rx_tick | input | 1 | Receive baud-rate generator enable |
| dce_txc_in | input | 1 | Incoming transmitter-timing lead (asynchronous level) |
| dce_rxc_in | input | 1 | Incoming receiver-timing lead (asynchronous level) |
| iso_stop_en | input | 1 | Arms isochronous input throttling |
| rx_stop_req | input | 1 | Receive side asks for the input to pause |
| tx_bit_tick | output | 1 | Selected transmit bit enable |
| rx_bit_tick | output | 1 | Selected receive bit enable |
| timing_out_a | output | 1 | First outgoing timing circuit |
| timing_out_b | output | 1 | Second outgoing timing circuit |

## Verification
The assertions assume three things about the inputs. Reset is applied before use. Each incoming timing lead holds each level for several system cycles. Generator enables are single pulses spaced at least two cycles apart, so each high phase of a routed clock lasts several cycles. The stimulus drives generator enables every three or four cycles and keeps each lead level for at least five cycles. Mode and stop changes are made only at points where the assertions require a low output. The sweeps compare edge counts and pulse lengths against values worked out from the drive pattern, so mid-pulse switching or stopping shows up as a short pulse or a wrong count.

// File: rtl/iso_clk_pkg.sv
package iso_clk_pkg;
    localparam int FIELD_W = 3;
    localparam int MODE_W  = 4 * FIELD_W;

    typedef enum logic [1:0] {
        IN_BRG    = 2'd0,
        IN_EXT_TX = 2'd1,
        IN_EXT_RX = 2'd2
    } in_src_e;

    typedef enum logic [FIELD_W-1:0] {
        OUT_OFF    = 3'd0,
        OUT_BRG_RX = 3'd1,
        OUT_BRG_TX = 3'd2,
        OUT_EXT_TX = 3'd3,
        OUT_EXT_RX = 3'd4
    } out_src_e;

    typedef struct packed {
        logic ext_rx;
        logic ext_tx;
        logic brg_tx;
        logic brg_rx;
    } src_vec_t;

    function automatic in_src_e decode_in(input logic [FIELD_W-1:0] code);
        case (code)
            FIELD_W'(1): return IN_EXT_TX;
            FIELD_W'(2): return IN_EXT_RX;
            default:     return IN_BRG;
        endcase
    endfunction

    function automatic out_src_e decode_out(input logic [FIELD_W-1:0] code);
        case (code)
            FIELD_W'(1): return OUT_BRG_RX;
            FIELD_W'(2): return OUT_BRG_TX;
            FIELD_W'(3): return OUT_EXT_TX;
            FIELD_W'(4): return OUT_EXT_RX;
            default:     return OUT_OFF;
        endcase
    endfunction

    function automatic logic out_level(input out_src_e s, input src_vec_t v);
        case (s)
            OUT_BRG_RX: return v.brg_rx;
            OUT_BRG_TX: return v.brg_tx;
            OUT_EXT_TX: return v.ext_tx;
            OUT_EXT_RX: return v.ext_rx;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/iso_edge_sync.sv
module iso_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_o,
    output logic tick_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], raw_in};
        s_d.prev  = s_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.chain[SYNC_STAGES-1];
    // rising edge of the synchronised level, one cycle wide
    assign tick_o  = s_q.chain[SYNC_STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/iso_tick_sel.sv
module iso_tick_sel
    import iso_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] code,
    input  logic               brg_tick,
    input  logic               ext_tx_tick,
    input  logic               ext_rx_tick,
    output logic               tick_o
);
    typedef struct packed {
        logic tick;
    } st_t;

    st_t     s_d, s_q;
    in_src_e src;

    always_comb begin
        src = decode_in(code);
        s_d = s_q;
        case (src)
            IN_EXT_TX: s_d.tick = ext_tx_tick;
            IN_EXT_RX: s_d.tick = ext_rx_tick;
            default:   s_d.tick = brg_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;
endmodule

// File: rtl/iso_timing_out.sv
module iso_timing_out
    import iso_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] code,
    input  src_vec_t           src_lvl,
    input  logic               stop_i,
    output logic               out_o,
    output logic [FIELD_W-1:0] sel_o,
    output logic               gate_o
);
    typedef struct packed {
        out_src_e sel;
        logic     gate;
        logic     out;
    } st_t;

    st_t      s_d, s_q;
    out_src_e req;
    logic     safe;

    always_comb begin
        req  = decode_out(code);
        // a boundary where neither the output nor the requested source is high
        safe = !s_q.out && !out_level(req, src_lvl);
        s_d  = s_q;
        if (safe) begin
            s_d.sel  = req;
            s_d.gate = stop_i;
        end
        s_d.out = !s_d.gate && out_level(s_d.sel, src_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_o  = s_q.out;
    assign sel_o  = s_q.sel;
    assign gate_o = s_q.gate;
endmodule

// File: rtl/iso_clk_router.sv
module iso_clk_router
    import iso_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] clk_mode,
    input  logic              brg_tx_tick,
    input  logic              brg_rx_tick,
    input  logic              dce_txc_in,
    input  logic              dce_rxc_in,
    input  logic              iso_stop_en,
    input  logic              rx_stop_req,
    output logic              tx_bit_tick,
    output logic              rx_bit_tick,
    output logic              timing_out_a,
    output logic              timing_out_b
);
    localparam int NUM_EXT = 2;
    localparam int NUM_DIR = 2;
    localparam int NUM_OUT = 2;
    localparam int OUT_LSB = NUM_DIR * FIELD_W;

    typedef struct packed {
        logic tx_lvl;
        logic rx_lvl;
    } brg_t;

    brg_t brg_d, brg_q;

    always_comb begin
        brg_d        = brg_q;
        brg_d.tx_lvl = brg_q.tx_lvl ^ brg_tx_tick;
        brg_d.rx_lvl = brg_q.rx_lvl ^ brg_rx_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brg_q <= '0;
        else        brg_q <= brg_d;
    end

    // index 0: transmitter-timing lead, index 1: receiver-timing lead
    logic [NUM_EXT-1:0] ext_raw, ext_lvl, ext_tick;
    assign ext_raw = {dce_rxc_in, dce_txc_in};

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        iso_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (ext_raw[g]),
            .level_o (ext_lvl[g]),
            .tick_o  (ext_tick[g])
        );
    end

    // index 0: transmit direction, index 1: receive direction
    logic [NUM_DIR-1:0] brg_ticks, dir_tick;
    assign brg_ticks = {brg_rx_tick, brg_tx_tick};

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        iso_tick_sel u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .code        (clk_mode[g*FIELD_W +: FIELD_W]),
            .brg_tick    (brg_ticks[g]),
            .ext_tx_tick (ext_tick[0]),
            .ext_rx_tick (ext_tick[1]),
            .tick_o      (dir_tick[g])
        );
    end

    src_vec_t src_lvl;
    logic     any_driven;
    logic     stop_eff;

    always_comb begin
        src_lvl.brg_rx = brg_q.rx_lvl;
        src_lvl.brg_tx = brg_q.tx_lvl;
        src_lvl.ext_tx = ext_lvl[0];
        src_lvl.ext_rx = ext_lvl[1];
        any_driven = 1'b0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (decode_out(clk_mode[OUT_LSB + i*FIELD_W +: FIELD_W]) != OUT_OFF)
                any_driven = 1'b1;
        end
        stop_eff = iso_stop_en && rx_stop_req && any_driven;
    end

    logic [NUM_OUT-1:0]              tout, tgate;
    logic [NUM_OUT-1:0][FIELD_W-1:0] tsel;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        iso_timing_out u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (clk_mode[OUT_LSB + g*FIELD_W +: FIELD_W]),
            .src_lvl (src_lvl),
            .stop_i  (stop_eff),
            .out_o   (tout[g]),
            .sel_o   (tsel[g]),
            .gate_o  (tgate[g])
        );
    end

    assign tx_bit_tick  = dir_tick[0];
    assign rx_bit_tick  = dir_tick[1];
    assign timing_out_a = tout[0];
    assign timing_out_b = tout[1];
endmodule

// File: rtl/iso_clk_router_chk.sv
module iso_clk_router_chk
    import iso_clk_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            tout,
    input logic [1:0][FIELD_W-1:0] tsel,
    input logic [1:0]            tgate,
    input logic [1:0]            ext_tick
);
    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R9: source selection only moves while the output was low
        assert_switch_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(tsel[g]) |-> !$past(tout[g]));

        // R7: stop gate only toggles while the output was low
        assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(tgate[g]) |-> !$past(tout[g]));

        // R7: a closed gate keeps the output low
        assert_stopped_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            tgate[g] |=> !tout[g]);

        // R6: an undriven selection gives a low output
        assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tsel[g] == OUT_OFF) |=> !tout[g]);

        // R10: each synchronised edge tick lasts one cycle
        assert_ext_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ext_tick[g] |=> !ext_tick[g]);
    end
endmodule

bind iso_clk_router iso_clk_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tout     (tout),
    .tsel     (tsel),
    .tgate    (tgate),
    .ext_tick (ext_tick)
);

// File: tb/iso_clk_router_test.sv
module iso_clk_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] clk_mode = '0;
    logic        brg_tx_tick = 1'b0, brg_rx_tick = 1'b0;
    logic        dce_txc_in = 1'b0, dce_rxc_in = 1'b0;
    logic        iso_stop_en = 1'b0, rx_stop_req = 1'b0;
    logic        tx_bit_tick, rx_bit_tick, timing_out_a, timing_out_b;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    iso_clk_router uut (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode),
        .brg_tx_tick(brg_tx_tick), .brg_rx_tick(brg_rx_tick),
        .dce_txc_in(dce_txc_in), .dce_rxc_in(dce_rxc_in),
        .iso_stop_en(iso_stop_en), .rx_stop_req(rx_stop_req),
        .tx_bit_tick(tx_bit_tick), .rx_bit_tick(rx_bit_tick),
        .timing_out_a(timing_out_a), .timing_out_b(timing_out_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // window pattern: 30 tx enables, 40 rx enables, 12 txc edges, 8 rxc edges
    function automatic int exp_in(input int code, input bit is_tx);
        if (code == 1) return 12;
        if (code == 2) return 8;
        return is_tx ? 30 : 40;
    endfunction

    function automatic int exp_out(input int code);
        case (code)
            1: return 20;
            2: return 15;
            3: return 12;
            4: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_in(input int code, input bit is_tx);
        if (code == 1 || code == 2) return is_tx ? "R1 R10" : "R2 R10";
        if (code >= 3) return is_tx ? "R1 R3" : "R2 R3";
        return is_tx ? "R1" : "R2";
    endfunction

    task automatic run_window(input int tx, input int rx, input int a, input int b);
        int c_tx = 0, c_rx = 0, c_a = 0, c_b = 0;
        logic pa = 1'b0, pb = 1'b0;
        clk_mode = {b[2:0], a[2:0], rx[2:0], tx[2:0]};
        for (int t = 0; t < 128; t++) begin
            @(negedge clk);
            if (tx_bit_tick) c_tx++;
            if (rx_bit_tick) c_rx++;
            if (timing_out_a && !pa) c_a++;
            if (timing_out_b && !pb) c_b++;
            pa = timing_out_a;
            pb = timing_out_b;
            if (t < 120) begin
                brg_rx_tick = (t % 3 == 2);
                brg_tx_tick = (t % 4 == 3);
                dce_txc_in  = ((t % 10) >= 5);
                dce_rxc_in  = (t < 112) && ((t % 14) >= 7);
            end else begin
                brg_rx_tick = 1'b0;
                brg_tx_tick = 1'b0;
                dce_txc_in  = 1'b0;
                dce_rxc_in  = 1'b0;
            end
        end
        check(c_tx == exp_in(tx, 1'b1), tag_in(tx, 1'b1), c_tx, exp_in(tx, 1'b1));
        check(c_rx == exp_in(rx, 1'b0), tag_in(rx, 1'b0), c_rx, exp_in(rx, 1'b0));
        check(c_a == exp_out(a), (a >= 5 || a == 0) ? "R4 R6" : "R4", c_a, exp_out(a));
        check(c_b == exp_out(b), (b >= 5 || b == 0) ? "R5 R6" : "R5", c_b, exp_out(b));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int run, rises_stop, rises_late;
        logic prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit_tick == 1'b0, "R11", tx_bit_tick, 0);
        check(rx_bit_tick == 1'b0, "R11", rx_bit_tick, 0);
        check(timing_out_a == 1'b0, "R11", timing_out_a, 0);
        check(timing_out_b == 1'b0, "R11", timing_out_b, 0);

        // field sweeps: every code of every field in two offset passes
        for (int c = 0; c < 8; c++) run_window(c, (c + 3) % 8, c, (c + 5) % 8);
        for (int c = 0; c < 8; c++) run_window((c + 6) % 8, c, (c + 2) % 8, c);

        // R7: throttled stop of output A driven by the transmit generator level
        clk_mode = {3'd0, 3'd2, 3'd0, 3'd0};
        iso_stop_en = 1'b1;
        run = 0; rises_stop = 0; rises_late = 0; prev = 1'b0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (timing_out_a) run++;
            else if (run > 0) begin
                check(run == 4, "R7 pulse length", run, 4);
                run = 0;
            end
            if (timing_out_a && !prev && t >= 70 && t < 130) rises_stop++;
            if (timing_out_a && !prev && t >= 140) rises_late++;
            prev = timing_out_a;
            brg_tx_tick = (t % 4 == 3);
            rx_stop_req = (t >= 50 && t < 130);
        end
        check(rises_stop == 0, "R7 stopped", rises_stop, 0);
        check(rises_late >= 7, "R7 resumed", rises_late, 7);

        // R8: request without arming has no effect
        iso_stop_en = 1'b0;
        rx_stop_req = 1'b1;
        rises_late = 0;
        for (int t = 0; t < 80; t++) begin
            @(negedge clk);
            if (timing_out_a) run++;
            else if (run > 0) begin
                check(run == 4, "R8 pulse length", run, 4);
                run = 0;
            end
            if (timing_out_a && !prev) rises_late++;
            prev = timing_out_a;
            brg_tx_tick = (t % 4 == 3);
        end
        check(rises_late >= 9, "R8 running", rises_late, 9);
        rx_stop_req = 1'b0;

        // R9: switch output A from transmit to receive generator mid-stream
        rises_late = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (timing_out_a) run++;
            else if (run > 0) begin
                check(run == 3 || run == 4, "R9 pulse length", run, 4);
                run = 0;
            end
            if (timing_out_a && !prev && t >= 100) rises_late++;
            prev = timing_out_a;
            brg_tx_tick = (t % 4 == 3);
            brg_rx_tick = (t % 3 == 2);
            if (t == 37) clk_mode = {3'd0, 3'd1, 3'd0, 3'd0};
        end
        check(rises_late >= 15, "R9 new source", rises_late, 15);
        brg_tx_tick = 1'b0;
        brg_rx_tick = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule